// File: doc/BRIEF.md
# Critical Word First Line Fill Controller

This block manages the refill of one multi-word cache line after a miss. When a miss is accepted, the block asks memory for the line. The request names the word the processor wanted, and memory starts the line at that word. Memory then sends one word per beat in wrap-around order. The first beat is passed straight to the processor in the cycle it arrives, so the processor can restart while the rest of the line is still being written into the line storage.

Each word of the line has its own valid bit, so a partly filled line can serve accesses. A processor access to a word that has already arrived reports a hit, and its data comes from the line storage. An access to a word that has not arrived yet reports a stall. The block returns that word to the processor in the cycle its beat arrives. A pulse marks the end of the fill. The block accepts no new miss until the current fill is complete.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, fill_done, store_we, cpu_rsp_valid and every line_valid bit are 0.
- R2: The cycle after a miss is accepted (miss_valid and miss_ready both 1), mem_req_valid is 1 and carries the accepted line and word offset. It stays 1 with those values until the cycle in which mem_req_ready is 1.
- R3: After the request is taken, beat k of the fill (counting from 0, one per cycle with mem_beat_valid at 1) writes word (offset + k) mod WORDS. In that same cycle it raises store_we, with store_word set to that index and store_data equal to mem_beat_data.
- R4: The first beat of a fill raises cpu_rsp_valid in the same cycle, with cpu_rsp_word equal to the missed offset and cpu_rsp_data equal to the beat data.
- R5: All line_valid bits are 0 in the cycle after a miss is accepted. Bit i becomes 1 in the cycle after the beat that writes word i, and it stays 1 until the next accepted miss.
- R6: acc_hit equals acc_valid AND line_valid[acc_word]. acc_stall equals acc_valid AND NOT line_valid[acc_word] while a fill is in progress (miss_ready at 0). Both are 0 when acc_valid is 0.
- R7: A later beat raises cpu_rsp_valid only when acc_valid is 1 and acc_word equals the index that beat writes. The block then forwards the word and index. In all other cycles cpu_rsp_valid is 0.
- R8: fill_done is 1 for exactly one cycle, the cycle after the last beat. In that cycle every line_valid bit is 1 and miss_ready is 1 again.
- R9: miss_ready is 0 from the cycle after a miss is accepted until the fill completes. A miss_valid in that period produces no new memory request and leaves line_valid unchanged.
- R10: mem_beat_valid has no effect while no request has been taken: no store write, no processor return and no change to line_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | log2(WORDS) | Word offset the processor wanted |
| miss_ready | output | 1 | Block can accept a miss |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_line | output | LINE_W | Requested line address |
| mem_req_word | output | log2(WORDS) | Word memory must return first |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_beat_valid | input | 1 | One data word from memory |
| mem_beat_data | input | DATA_W | Data of the beat |
| store_we | output | 1 | Write strobe to line storage |
| store_word | output | log2(WORDS) | Word index written |
| store_data | output | DATA_W | Data written |
| cpu_rsp_valid | output | 1 | Word forwarded to the processor |
| cpu_rsp_word | output | log2(WORDS) | Index of forwarded word |
| cpu_rsp_data | output | DATA_W | Forwarded data |
| acc_valid | input | 1 | Processor access to the filling line |
| acc_word | input | log2(WORDS) | Word index of that access |
| acc_hit | output | 1 | Accessed word is already resident |
| acc_stall | output | 1 | Accessed word not yet arrived |
| line_valid | output | WORDS | Per-word valid bits |
| fill_done | output | 1 | One-cycle end-of-fill pulse |

## Verification
The bench builds the block with WORDS = 8, DATA_W = 16 and LINE_W = 10. It sends random miss offsets, so every start position occurs, and the wrap from word 7 back to word 0 happens at every point in the beat sequence. Memory acceptance and beat gaps are random, so requests wait and beats arrive unevenly. Misses and beats also arrive while the block is busy or idle, which exercises the ignored-input cases. Access indices are random, so the same run sweeps hits, stalls and stalls resolved by a forwarded beat against a behavioural model. Only the power-of-two wrap variant is reached with these values.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_REQ   = 2'd1,
      FS_BEATS = 2'd2
   } fill_state_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq #(
   parameter int WORDS = 8,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFF_W-1:0] start_i,
   input  logic             step_i,
   output logic [OFF_W-1:0] word_o,
   output logic             first_o,
   output logic             last_o
);
   localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);

   logic [OFF_W-1:0] start_q;
   logic [OFF_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         cnt_q   <= '0;
      end else if (load_i) begin
         start_q <= start_i;
         cnt_q   <= '0;
      end else if (step_i) begin
         cnt_q <= last_o ? '0 : cnt_q + OFF_W'(1);
      end
   end

   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == LAST_CNT);

   generate
      if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
         assign word_o = start_q + cnt_q;
      end else begin : g_mod
         localparam logic [OFF_W:0] LIMIT = (OFF_W + 1)'(WORDS);
         logic [OFF_W:0] sum;
         always_comb begin
            sum = {1'b0, start_q} + {1'b0, cnt_q};
            if (sum >= LIMIT) sum = sum - LIMIT;
         end
         assign word_o = sum[OFF_W-1:0];
      end
   endgenerate

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !load_i && last_o |=> first_o);
endmodule

// File: rtl/cwf_valid_bits.sv
module cwf_valid_bits #(
   parameter int WORDS = 8,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             set_i,
   input  logic [OFF_W-1:0] set_word_i,
   output logic [WORDS-1:0] valid_o
);
   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               valid_o[i] <= 1'b0;
            else if (clr_i)
               valid_o[i] <= 1'b0;
            else if (set_i && set_word_i == OFF_W'(i))
               valid_o[i] <= 1'b1;
         end
      end
   endgenerate

   // R5
   valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((valid_o & $past(valid_o)) == $past(valid_o)));

   // R5
   valid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ($countones(valid_o) <= $countones($past(valid_o)) + 1));
endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
   import cwf_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int OFF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid_i,
   input  logic [LINE_W-1:0] miss_line_i,
   input  logic [OFF_W-1:0]  miss_word_i,
   output logic              miss_ready_o,
   output logic              req_valid_o,
   output logic [LINE_W-1:0] req_line_o,
   output logic [OFF_W-1:0]  req_word_o,
   input  logic              req_ready_i,
   output logic              accept_o,
   output logic              in_beats_o,
   input  logic              beat_take_i,
   input  logic              beat_last_i,
   output logic              done_o
);
   fill_state_e state_q, state_d;

   assign miss_ready_o = (state_q == FS_IDLE);
   assign accept_o     = miss_valid_i && miss_ready_o;
   assign req_valid_o  = (state_q == FS_REQ);
   assign in_beats_o   = (state_q == FS_BEATS);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_IDLE:  if (accept_o) state_d = FS_REQ;
         FS_REQ:   if (req_ready_i) state_d = FS_BEATS;
         FS_BEATS: if (beat_take_i && beat_last_i) state_d = FS_IDLE;
         default:  state_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= FS_IDLE;
         req_line_o <= '0;
         req_word_o <= '0;
         done_o     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= beat_take_i && beat_last_i;
         if (accept_o) begin
            req_line_o <= miss_line_i;
            req_word_o <= miss_word_i;
         end
      end
   end

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_word_o) && $stable(req_line_o));

   // R8
   done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> miss_ready_o);
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
   parameter int WORDS  = 8,
   parameter int DATA_W = 32,
   parameter int LINE_W = 26,
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_valid,
   input  logic [LINE_W-1:0] miss_line,
   input  logic [OFF_W-1:0]  miss_word,
   output logic              miss_ready,
   output logic              mem_req_valid,
   output logic [LINE_W-1:0] mem_req_line,
   output logic [OFF_W-1:0]  mem_req_word,
   input  logic              mem_req_ready,
   input  logic              mem_beat_valid,
   input  logic [DATA_W-1:0] mem_beat_data,
   output logic              store_we,
   output logic [OFF_W-1:0]  store_word,
   output logic [DATA_W-1:0] store_data,
   output logic              cpu_rsp_valid,
   output logic [OFF_W-1:0]  cpu_rsp_word,
   output logic [DATA_W-1:0] cpu_rsp_data,
   input  logic              acc_valid,
   input  logic [OFF_W-1:0]  acc_word,
   output logic              acc_hit,
   output logic              acc_stall,
   output logic [WORDS-1:0]  line_valid,
   output logic              fill_done
);
   generate
      if (WORDS < 2) begin : g_bad_words
         $error("WORDS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (LINE_W < 1) begin : g_bad_line
         $error("LINE_W must be at least 1");
      end
   endgenerate

   logic             accept;
   logic             in_beats;
   logic             beat_take;
   logic             beat_first;
   logic             beat_last;
   logic [OFF_W-1:0] beat_word;
   logic             acc_match;
   logic             word_ok;

   assign beat_take = mem_beat_valid && in_beats;

   cwf_fill_ctrl #(.LINE_W(LINE_W), .OFF_W(OFF_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid_i (miss_valid),
      .miss_line_i  (miss_line),
      .miss_word_i  (miss_word),
      .miss_ready_o (miss_ready),
      .req_valid_o  (mem_req_valid),
      .req_line_o   (mem_req_line),
      .req_word_o   (mem_req_word),
      .req_ready_i  (mem_req_ready),
      .accept_o     (accept),
      .in_beats_o   (in_beats),
      .beat_take_i  (beat_take),
      .beat_last_i  (beat_last),
      .done_o       (fill_done)
   );

   cwf_wrap_seq #(.WORDS(WORDS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .start_i (miss_word),
      .step_i  (beat_take),
      .word_o  (beat_word),
      .first_o (beat_first),
      .last_o  (beat_last)
   );

   cwf_valid_bits #(.WORDS(WORDS)) u_valid (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept),
      .set_i      (beat_take),
      .set_word_i (beat_word),
      .valid_o    (line_valid)
   );

   assign store_we   = beat_take;
   assign store_word = beat_word;
   assign store_data = mem_beat_data;

   assign word_ok       = line_valid[acc_word];
   assign acc_match     = acc_valid && (acc_word == beat_word);
   assign cpu_rsp_valid = beat_take && (beat_first || acc_match);
   assign cpu_rsp_word  = beat_word;
   assign cpu_rsp_data  = mem_beat_data;

   assign acc_hit   = acc_valid && word_ok;
   assign acc_stall = acc_valid && !word_ok && !miss_ready;

   // R8
   done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |-> (&line_valid));

   // R3
   store_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |-> !line_valid[store_word]);

   // R4
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_we && (line_valid == '0) |-> cpu_rsp_valid && (cpu_rsp_word == mem_req_word));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !miss_ready && !fill_done |=> !$rose(mem_req_valid));
endmodule

// File: tb/cwf_line_fill_test.sv
`timescale 1ns/1ps
module cwf_line_fill_test;
   localparam int W   = 8;
   localparam int DW  = 16;
   localparam int LW  = 10;
   localparam int OW  = 3;
   localparam int RUN = 6000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [LW-1:0] miss_line = '0;
   logic [OW-1:0] miss_word = '0;
   logic          miss_ready;
   logic          mem_req_valid;
   logic [LW-1:0] mem_req_line;
   logic [OW-1:0] mem_req_word;
   logic          mem_req_ready = 1'b0;
   logic          mem_beat_valid = 1'b0;
   logic [DW-1:0] mem_beat_data = '0;
   logic          store_we;
   logic [OW-1:0] store_word;
   logic [DW-1:0] store_data;
   logic          cpu_rsp_valid;
   logic [OW-1:0] cpu_rsp_word;
   logic [DW-1:0] cpu_rsp_data;
   logic          acc_valid = 1'b0;
   logic [OW-1:0] acc_word = '0;
   logic          acc_hit;
   logic          acc_stall;
   logic [W-1:0]  line_valid;
   logic          fill_done;

   always #2 clk = ~clk;

   cwf_line_fill #(.WORDS(W), .DATA_W(DW), .LINE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_ready(miss_ready),
      .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_word(mem_req_word),
      .mem_req_ready(mem_req_ready),
      .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
      .store_we(store_we), .store_word(store_word), .store_data(store_data),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_word(cpu_rsp_word), .cpu_rsp_data(cpu_rsp_data),
      .acc_valid(acc_valid), .acc_word(acc_word), .acc_hit(acc_hit), .acc_stall(acc_stall),
      .line_valid(line_valid), .fill_done(fill_done)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // behavioural reference state
   int m_state = 0;   // 0 idle, 1 waiting for request take, 2 receiving beats
   int m_line = 0;
   int m_start = 0;
   int m_cnt = 0;
   int m_vld[W];
   int m_done = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int vld_vec();
      int v = 0;
      for (int i = 0; i < W; i++) v = v | (m_vld[i] << i);
      return v;
   endfunction

   task automatic compare();
      int take;
      int bw;
      int rsp;
      take = (mem_beat_valid && m_state == 2) ? 1 : 0;
      bw = (m_start + m_cnt) % W;
      chk("R9", "miss_ready", int'(miss_ready), (m_state == 0) ? 1 : 0);
      chk("R2", "mem_req_valid", int'(mem_req_valid), (m_state == 1) ? 1 : 0);
      if (m_state == 1) begin
         chk("R2", "mem_req_line", int'(mem_req_line), m_line);
         chk("R2", "mem_req_word", int'(mem_req_word), m_start);
      end
      if (m_state == 2) chk("R3", "store_we", int'(store_we), take);
      else              chk("R10", "store_we", int'(store_we), 0);
      if (take) begin
         chk("R3", "store_word", int'(store_word), bw);
         chk("R3", "store_data", int'(store_data), int'(mem_beat_data));
      end
      rsp = (take && (m_cnt == 0 || (acc_valid && int'(acc_word) == bw))) ? 1 : 0;
      if (take && m_cnt == 0) chk("R4", "cpu_rsp_valid", int'(cpu_rsp_valid), rsp);
      else                    chk("R7", "cpu_rsp_valid", int'(cpu_rsp_valid), rsp);
      if (rsp) begin
         chk(m_cnt == 0 ? "R4" : "R7", "cpu_rsp_word", int'(cpu_rsp_word), bw);
         chk(m_cnt == 0 ? "R4" : "R7", "cpu_rsp_data", int'(cpu_rsp_data), int'(mem_beat_data));
      end
      chk("R6", "acc_hit", int'(acc_hit), (acc_valid && m_vld[acc_word] == 1) ? 1 : 0);
      chk("R6", "acc_stall", int'(acc_stall),
          (acc_valid && m_vld[acc_word] == 0 && m_state != 0) ? 1 : 0);
      chk("R5", "line_valid", int'(line_valid), vld_vec());
      chk("R8", "fill_done", int'(fill_done), m_done);
   endtask

   task automatic model_step();
      int take;
      int bw;
      take = (mem_beat_valid && m_state == 2) ? 1 : 0;
      bw = (m_start + m_cnt) % W;
      m_done = (take && m_cnt == W - 1) ? 1 : 0;
      if (m_state == 0 && miss_valid) begin
         m_state = 1;
         m_line = int'(miss_line);
         m_start = int'(miss_word);
         for (int i = 0; i < W; i++) m_vld[i] = 0;
      end else if (m_state == 1 && mem_req_ready) begin
         m_state = 2;
         m_cnt = 0;
      end else if (take) begin
         m_vld[bw] = 1;
         if (m_cnt == W - 1) m_state = 0;
         else m_cnt++;
      end
   endtask

   initial begin
      for (int i = 0; i < W; i++) m_vld[i] = 0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1", "miss_ready", int'(miss_ready), 1);
      chk("R1", "mem_req_valid", int'(mem_req_valid), 0);
      chk("R1", "fill_done", int'(fill_done), 0);
      chk("R1", "store_we", int'(store_we), 0);
      chk("R1", "cpu_rsp_valid", int'(cpu_rsp_valid), 0);
      chk("R1", "line_valid", int'(line_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < RUN; cyc++) begin
         miss_valid     = ($urandom_range(0, 99) < 30);
         miss_line      = LW'($urandom);
         miss_word      = OW'($urandom_range(0, W - 1));
         mem_req_ready  = ($urandom_range(0, 99) < 50);
         mem_beat_valid = ($urandom_range(0, 99) < 70);
         mem_beat_data  = DW'($urandom);
         acc_valid      = ($urandom_range(0, 99) < 60);
         if ($urandom_range(0, 99) < 40) acc_word = OW'($urandom_range(0, W - 1));
         #1;
         compare();
         model_step();
         @(negedge clk);
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule